// File: doc/BRIEF.md
# Halt-Based Sprite and Sample DMA Arbiter

This block sits beside a CPU core and takes over its memory bus for two DMA channels. The sprite channel copies one 256-byte memory page, byte by byte, into a fixed write port. The sample channel fetches a single byte for the audio unit. A request on either channel does not take the bus at once. It waits for a cycle in which the CPU is about to read, and turns that cycle into a halt cycle. From then on `dma_active` holds the CPU stalled until both channels are idle.

Each bus cycle is classed by the parity of the cycle count since reset. Even cycles are get slots and odd cycles are put slots. Reads of either channel happen only on get slots, and port writes happen only on put slots. A sample fetch becomes eligible only after one halt credit and one dummy-read credit. Cycles spent on sprite DMA pay those credits. Once the sample fetch is eligible, it wins the next get slot over the sprite channel. The sample channel can be stopped at any point, and the result depends on how far it has progressed.

Top module: `dma_halt_arbiter`

## Requirements
- R1: After reset, `dma_active`, `bus_rd`, `bus_wr` and `smp_valid` are all low and stay low until a request is made.
- R2: A pending request takes the bus only in a cycle where `cpu_rd` is high. That first active cycle is a read of `cpu_addr` whose data is discarded.
- R3: The first cycle after reset release is a get slot, and slots then alternate get/put. Sprite and sample reads occur only on get slots, port writes only on put slots, and no cycle both reads and writes.
- R4: A sprite transfer reads `{spr_page, i}` for i = 0 to 255 in ascending order. Each byte read is written to address 0x2004 on the following put slot, giving exactly 256 reads and 256 writes.
- R5: A sprite transfer alone keeps `dma_active` high for 513 cycles when the halt cycle is a put slot, and 514 cycles when it is a get slot.
- R6: A sample fetch alone reads `smp_addr` on the first get slot at or after the third active cycle, so `dma_active` is high for 3 or 4 cycles. `smp_valid` pulses for exactly one cycle, the cycle after the read, with `smp_data` equal to the byte read.
- R7: A sample request made in cycle S (or before the halt cycle, counting S as the cycle before it) reads on the first get slot at or after S+3, even while a sprite transfer runs. The sprite transfer is then lengthened by exactly 2 cycles and still copies all bytes correctly.
- R8: `smp_halt` raised before the sample's halt cycle cancels the sample. With no sprite pending, the bus is never taken, no sample read occurs and `smp_valid` never pulses.
- R9: `smp_halt` raised in an active cycle after the halt cycle aborts the sample at the next cycle. With no sprite pending, the sample fetched alone on a halt at a get slot ends after 3 active cycles with no sample read and no `smp_valid`.
- R10: `smp_halt` raised during the halt cycle with no sprite pending ends DMA right away, after exactly 1 active cycle.
- R11: `dma_active` stays high without a gap from the halt cycle to the last DMA cycle, then falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one CPU cycle per edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_rd | input | 1 | CPU intends a read this cycle |
| cpu_addr | input | ADDR_W | Address of the CPU's pending read |
| spr_go | input | 1 | Pulse: start a sprite page copy |
| spr_page | input | ADDR_W-8 | Source page number for the sprite copy |
| smp_go | input | 1 | Pulse: start a sample byte fetch |
| smp_halt | input | 1 | Pulse: stop the sample fetch |
| smp_addr | input | ADDR_W | Address of the sample byte |
| bus_rdata | input | DATA_W | Read data returned by the bus |
| dma_active | output | 1 | Bus owned by DMA; CPU must stall |
| bus_rd | output | 1 | DMA read strobe |
| bus_wr | output | 1 | DMA write strobe |
| bus_addr | output | ADDR_W | DMA bus address |
| bus_wdata | output | DATA_W | DMA write data |
| smp_valid | output | 1 | One-cycle pulse: sample byte delivered |
| smp_data | output | DATA_W | Delivered sample byte |

## Verification
A wrong credit flag shows up within a few cycles as a sample read one get slot early or late, counted from the request or halt cycle. A wrong parity or sprite counter shows up as a put-slot read, a misordered page index or a wrong write byte. Each of these can be seen on the first beat of the copy. Stop handling is judged by the number of active cycles and by whether `smp_valid` pulses at all, both settled within four cycles of the stop. The bench sweeps four pages, both halt parities and several join points for the sample request. For each run it predicts the total length and the slot of the sample read.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_HALT,
    OP_DUMMY,
    OP_SMP_RD,
    OP_SPR_RD,
    OP_SPR_WR
  } dma_op_e;

  // even slot count -> get slot
  function automatic logic slot_is_get(input logic par_q);
    return ~par_q;
  endfunction

  // an operation that reads the bus
  function automatic logic op_reads(input dma_op_e op);
    return (op == OP_HALT) || (op == OP_DUMMY) ||
           (op == OP_SMP_RD) || (op == OP_SPR_RD);
  endfunction

endpackage

// File: rtl/dma_sprite_chan.sv
module dma_sprite_chan #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int XFER_LEN = 256,
  localparam int IDX_W = $clog2(XFER_LEN),
  localparam int CNT_W = IDX_W + 1,
  localparam int PAGE_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PAGE_W-1:0] page_in,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] rdata,
  output logic              pend,
  output logic              cnt_odd,
  output logic              last_beat,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] held
);

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(2 * XFER_LEN - 1);

  logic              pend_q;
  logic [PAGE_W-1:0] page_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] held_q;

  // source address: page in upper bits, beat counter halved as index
  function automatic logic [ADDR_W-1:0] src_addr(input logic [PAGE_W-1:0] pg,
                                                 input logic [CNT_W-1:0] c);
    return {pg, c[IDX_W:1]};
  endfunction

  assign last_beat = wr_stb && (cnt_q == LAST_CNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      page_q <= '0;
      cnt_q  <= '0;
      held_q <= '0;
    end else if (start) begin
      pend_q <= 1'b1;
      page_q <= page_in;
      cnt_q  <= '0;
    end else begin
      if (rd_stb) begin
        held_q <= rdata;
        cnt_q  <= cnt_q + 1'b1;
      end
      if (wr_stb) begin
        cnt_q <= last_beat ? '0 : cnt_q + 1'b1;
        if (last_beat) pend_q <= 1'b0;
      end
    end
  end

  assign pend    = pend_q;
  assign cnt_odd = cnt_q[0];
  assign rd_addr = src_addr(page_q, cnt_q);
  assign held    = held_q;

endmodule

// File: rtl/dma_sample_chan.sv
module dma_sample_chan #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              kill,
  input  logic              set_abort,
  input  logic              clr_dummy,
  input  logic              rd_stb,
  input  logic [DATA_W-1:0] rdata,
  output logic              run,
  output logic              need_dummy,
  output logic              abort_pend,
  output logic              valid,
  output logic [DATA_W-1:0] data
);

  logic run_q, dummy_q, abort_q, valid_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      dummy_q <= 1'b0;
      abort_q <= 1'b0;
    end else if (start) begin
      run_q   <= 1'b1;
      dummy_q <= 1'b1;
      abort_q <= 1'b0;
    end else if (kill) begin
      run_q   <= 1'b0;
      dummy_q <= 1'b0;
      abort_q <= 1'b0;
    end else if (rd_stb) begin
      run_q <= 1'b0;
    end else begin
      if (clr_dummy) dummy_q <= 1'b0;
      if (set_abort) abort_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= rd_stb;
      if (rd_stb) data_q <= rdata;
    end
  end

  assign run        = run_q;
  assign need_dummy = dummy_q;
  assign abort_pend = abort_q;
  assign valid      = valid_q;
  assign data       = data_q;

endmodule

// File: rtl/dma_halt_arbiter.sv
module dma_halt_arbiter
  import dma_arb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int XFER_LEN = 256,
  parameter logic [ADDR_W-1:0] PORT_ADDR = ADDR_W'(16'h2004),
  localparam int IDX_W = $clog2(XFER_LEN),
  localparam int PAGE_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_rd,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              spr_go,
  input  logic [PAGE_W-1:0] spr_page,
  input  logic              smp_go,
  input  logic              smp_halt,
  input  logic [ADDR_W-1:0] smp_addr,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              dma_active,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              smp_valid,
  output logic [DATA_W-1:0] smp_data
);

  // shared state
  logic parity_q, in_dma_q, need_halt_q;

  // channel state
  logic              spr_pend, spr_cnt_odd, spr_last;
  logic [ADDR_W-1:0] spr_addr;
  logic [DATA_W-1:0] spr_byte;
  logic              smp_run, smp_dummy, smp_abort;

  // named events
  logic    get_cyc, halt_cyc, abort_now, smp_ready;
  logic    halt_left, stop_eff, cancel, halt_kill, set_abort, kill, clr_dummy;
  logic    smp_rd_evt, spr_rd_evt, spr_wr_evt;
  logic    spr_pend_nx, smp_run_nx;
  dma_op_e op;

  assign get_cyc   = slot_is_get(parity_q);
  assign halt_cyc  = !in_dma_q && need_halt_q && cpu_rd;
  assign abort_now = in_dma_q && smp_abort;
  assign smp_ready = in_dma_q && smp_run && !abort_now && !need_halt_q && !smp_dummy;

  always_comb begin
    op = OP_IDLE;
    if (halt_cyc) begin
      op = OP_HALT;
    end else if (in_dma_q) begin
      if (get_cyc)
        op = smp_ready ? OP_SMP_RD : (spr_pend ? OP_SPR_RD : OP_DUMMY);
      else
        op = (spr_pend && spr_cnt_odd) ? OP_SPR_WR : OP_DUMMY;
    end
  end

  assign smp_rd_evt = (op == OP_SMP_RD);
  assign spr_rd_evt = (op == OP_SPR_RD);
  assign spr_wr_evt = (op == OP_SPR_WR);

  // credit consumption: every cycle inside DMA clears the halt credit
  assign halt_left = need_halt_q && !halt_cyc && !in_dma_q;
  assign clr_dummy = in_dma_q && !abort_now && !need_halt_q && smp_dummy;

  // stop handling, by progress of the sample channel
  assign stop_eff  = smp_halt && smp_run && !abort_now;
  assign cancel    = stop_eff && halt_left;
  assign halt_kill = stop_eff && halt_cyc;
  assign set_abort = stop_eff && !halt_left && !halt_cyc;
  assign kill      = abort_now || cancel || halt_kill;

  assign spr_pend_nx = (spr_pend && !spr_last) || spr_go;
  assign smp_run_nx  = (smp_run && !kill && !smp_rd_evt) || smp_go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      parity_q    <= 1'b0;
      in_dma_q    <= 1'b0;
      need_halt_q <= 1'b0;
    end else begin
      parity_q    <= ~parity_q;
      in_dma_q    <= (halt_cyc || in_dma_q) && (spr_pend_nx || smp_run_nx);
      need_halt_q <= (halt_left && !(cancel && !spr_pend)) || spr_go || smp_go;
    end
  end

  dma_sprite_chan #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .XFER_LEN(XFER_LEN)
  ) u_spr (
    .clk(clk), .rst_n(rst_n), .start(spr_go), .page_in(spr_page),
    .rd_stb(spr_rd_evt), .wr_stb(spr_wr_evt), .rdata(bus_rdata),
    .pend(spr_pend), .cnt_odd(spr_cnt_odd), .last_beat(spr_last),
    .rd_addr(spr_addr), .held(spr_byte)
  );

  dma_sample_chan #(.DATA_W(DATA_W)) u_smp (
    .clk(clk), .rst_n(rst_n), .start(smp_go), .kill(kill),
    .set_abort(set_abort), .clr_dummy(clr_dummy), .rd_stb(smp_rd_evt),
    .rdata(bus_rdata), .run(smp_run), .need_dummy(smp_dummy),
    .abort_pend(smp_abort), .valid(smp_valid), .data(smp_data)
  );

  always_comb begin
    unique case (op)
      OP_HALT, OP_DUMMY: bus_addr = cpu_addr;
      OP_SMP_RD:         bus_addr = smp_addr;
      OP_SPR_RD:         bus_addr = spr_addr;
      OP_SPR_WR:         bus_addr = PORT_ADDR;
      default:           bus_addr = '0;
    endcase
  end

  assign dma_active = (op != OP_IDLE);
  assign bus_rd     = op_reads(op);
  assign bus_wr     = spr_wr_evt;
  assign bus_wdata  = spr_wr_evt ? spr_byte : '0;

endmodule

// File: rtl/dma_halt_arbiter_chk.sv
module dma_halt_arbiter_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = ADDR_W'(16'h2004)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_rd,
  input logic              dma_active,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              smp_valid,
  input logic              get_cyc,
  input logic              smp_rd_evt,
  input logic              spr_rd_evt
);

  assert_rd_wr_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  assert_wr_on_put_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> !get_cyc);

  assert_fetch_on_get_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_rd_evt || spr_rd_evt) |-> get_cyc);

  assert_wr_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> (bus_addr == PORT_ADDR));

  assert_wr_after_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> $past(spr_rd_evt));

  assert_valid_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> $past(smp_rd_evt));

  assert_engage_on_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_active) |-> cpu_rd);

endmodule

bind dma_halt_arbiter dma_halt_arbiter_chk #(
  .ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .dma_active(dma_active),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .smp_valid(smp_valid), .get_cyc(get_cyc), .smp_rd_evt(smp_rd_evt),
  .spr_rd_evt(spr_rd_evt)
);

// File: tb/sim_dma_halt_arbiter.sv
`timescale 1ns/1ps
module sim_dma_halt_arbiter;

  localparam logic [15:0] CPU_A  = 16'hC123;
  localparam logic [15:0] SMP_A  = 16'hD0E7;
  localparam logic [15:0] PORT_A = 16'h2004;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cpu_rd = 1'b0, spr_go = 1'b0, smp_go = 1'b0, smp_halt = 1'b0;
  logic [15:0] cpu_addr = CPU_A, smp_addr = SMP_A;
  logic [7:0]  spr_page = 8'h00;
  logic [7:0]  bus_rdata;
  logic        dma_active, bus_rd, bus_wr, smp_valid;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata, smp_data;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return (a[7:0] ^ 8'hA5) + a[15:8];
  endfunction
  assign bus_rdata = memf(bus_addr);

  dma_halt_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
    .spr_go(spr_go), .spr_page(spr_page), .smp_go(smp_go), .smp_halt(smp_halt),
    .smp_addr(smp_addr), .bus_rdata(bus_rdata), .dma_active(dma_active),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .smp_valid(smp_valid), .smp_data(smp_data)
  );

  int cyc = 0;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // observation state
  int n_cyc, n_act, halt_pos, smp_rd_pos, val_pos, n_val, n_srd, n_wr;
  bit seq_err, par_err, data_err, val_err, halt_err, gap_err, fell;
  logic [7:0] last_byte, exp_idx, cur_page;

  task automatic clear_obs(input logic [7:0] pg);
    n_cyc = 0; n_act = 0; halt_pos = -1; smp_rd_pos = -1; val_pos = -1;
    n_val = 0; n_srd = 0; n_wr = 0; seq_err = 0; par_err = 0; data_err = 0;
    val_err = 0; halt_err = 0; gap_err = 0; fell = 0;
    last_byte = 8'h00; exp_idx = 8'h00; cur_page = pg;
  endtask

  task automatic observe();
    n_cyc++;
    if (dma_active) begin
      if (fell) gap_err = 1;
      n_act++;
      if (halt_pos < 0) begin
        halt_pos = n_cyc;
        if (!(bus_rd && bus_addr == CPU_A && !bus_wr && cpu_rd)) halt_err = 1;
      end
    end else if (n_act > 0) fell = 1;
    if (bus_wr) begin
      n_wr++;
      if (cyc % 2 == 0) par_err = 1;
      if (bus_addr != PORT_A || bus_wdata != last_byte) data_err = 1;
    end
    if (bus_rd && bus_addr == SMP_A) begin
      smp_rd_pos = n_cyc;
      if (cyc % 2 != 0) par_err = 1;
    end else if (bus_rd && bus_addr[15:8] == cur_page) begin
      if (bus_addr[7:0] != exp_idx) seq_err = 1;
      exp_idx++;
      n_srd++;
      last_byte = memf(bus_addr);
      if (cyc % 2 != 0) par_err = 1;
    end
    if (smp_valid) begin
      n_val++;
      val_pos = n_cyc;
      if (smp_data != memf(SMP_A)) val_err = 1;
    end
  endtask

  task automatic cyc_do(input logic rd, input logic sg, input logic mg, input logic mh);
    @(negedge clk);
    cpu_rd = rd; spr_go = sg; smp_go = mg; smp_halt = mh;
    #1 observe();
  endtask

  task automatic wait_parity(input int p);
    while (((cyc + 1) % 2) != p) cyc_do(0, 0, 0, 0);
  endtask

  // smp_k: -1 no sample, 0 sample requested with the first request, k>=2 joins at loop step k
  task automatic run_case(input bit do_spr, input logic [7:0] pg, input int smp_k, input int hp);
    int s_idx, j, exp_total;
    clear_obs(do_spr ? pg : 8'h55);
    spr_page = pg;
    cyc_do(0, do_spr, smp_k == 0, 0);
    cyc_do(0, 0, 0, 0);
    wait_parity(hp);
    cyc_do(1, 0, 0, 0);
    for (int i = 1; i < 800; i++) begin
      cyc_do(0, 0, (smp_k == i), 0);
      if (!dma_active) break;
    end
    cyc_do(0, 0, 0, 0);
    cyc_do(0, 0, 0, 0);

    if (do_spr) exp_total = (hp == 0) ? 514 : 513;
    else        exp_total = (hp == 0) ? 3 : 4;
    if (do_spr && smp_k >= 0) exp_total += 2;

    chk(!halt_err, "R2 halt cycle reads cpu_addr", halt_err, 0);
    chk(!par_err, "R3 slot parity", par_err, 0);
    chk(!gap_err && !dma_active, "R11 contiguous active window", gap_err, 0);
    if (do_spr) begin
      chk(n_srd == 256 && n_wr == 256, "R4 sprite beat counts", n_srd + n_wr, 512);
      chk(!seq_err, "R4 sprite read order", seq_err, 0);
      chk(!data_err, "R4 sprite write data", data_err, 0);
    end else begin
      chk(n_wr == 0, "R6 no writes for sample", n_wr, 0);
    end
    chk(n_act == exp_total, (do_spr && smp_k < 0) ? "R5 sprite length" :
        (do_spr ? "R7 joined length" : "R6 sample length"), n_act, exp_total);
    if (smp_k >= 0) begin
      s_idx = (smp_k == 0) ? 0 : smp_k + 1;
      j = s_idx + 3;
      if (((hp + j - 1) % 2) != 0) j++;
      chk(smp_rd_pos == halt_pos + j - 1, do_spr ? "R7 sample read slot" : "R6 sample read slot",
          smp_rd_pos - halt_pos + 1, j);
      chk(n_val == 1 && val_pos == smp_rd_pos + 1 && !val_err, "R6 sample delivery",
          val_pos - smp_rd_pos, 1);
    end
  endtask

  task automatic run_stop(input int mode);
    clear_obs(8'h55);
    cyc_do(0, 0, 1, 0);
    if (mode == 0) begin
      cyc_do(0, 0, 0, 1);
      repeat (6) cyc_do(1, 0, 0, 0);
      chk(n_act == 0, "R8 cancel keeps bus", n_act, 0);
      chk(smp_rd_pos < 0 && n_val == 0, "R8 cancel no fetch", n_val, 0);
    end else if (mode == 1) begin
      wait_parity(0);
      cyc_do(1, 0, 0, 1);
      repeat (6) cyc_do(0, 0, 0, 0);
      chk(n_act == 1, "R10 stop in halt cycle", n_act, 1);
      chk(smp_rd_pos < 0 && n_val == 0, "R10 no fetch", n_val, 0);
    end else begin
      wait_parity(0);
      cyc_do(1, 0, 0, 0);
      cyc_do(0, 0, 0, 1);
      repeat (6) cyc_do(0, 0, 0, 0);
      chk(n_act == 3, "R9 abort length", n_act, 3);
      chk(smp_rd_pos < 0 && n_val == 0, "R9 abort no fetch", n_val, 0);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!dma_active && !bus_rd && !bus_wr && !smp_valid, "R1 reset idle",
        dma_active + bus_rd + bus_wr + smp_valid, 0);
    clear_obs(8'h55);
    repeat (5) cyc_do(1, 0, 0, 0);
    chk(n_act == 0 && n_val == 0, "R1 idle without request", n_act, 0);

    run_stop(0);
    run_stop(1);
    run_stop(2);
    for (int hp = 0; hp < 2; hp++) run_case(0, 8'h00, 0, hp);
    for (int hp = 0; hp < 2; hp++) begin
      run_case(1, 8'h00, -1, hp);
      run_case(1, 8'h02, -1, hp);
      run_case(1, 8'h7F, -1, hp);
      run_case(1, 8'hFE, -1, hp);
    end
    for (int hp = 0; hp < 2; hp++) begin
      run_case(1, 8'h02, 0, hp);
      run_case(1, 8'h7F, 2, hp);
      run_case(1, 8'h10, 3, hp);
      run_case(1, 8'hFE, 101, hp);
    end
    run_case(0, 8'h00, 0, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R11 watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule